// File: doc/BRIEF.md
# Multi-Mode Register Shifter

A single register of parameter width that moves its contents by one bit position on each clock. A 3-bit operation code selects one of eight actions. The register can hold its value or load a parallel word. It can also perform a logical, circular or arithmetic shift, either left or right.

The logical shifts take the bit for the vacated end from one of two serial inputs, one for each direction. Tying a serial input low gives a plain zero-fill shift. The circular shifts feed the bit leaving one end back into the other end. The arithmetic shifts treat the register as a signed number: a right shift keeps the sign, and a left shift doubles the value. The left arithmetic shift also raises a registered overflow flag when the sign would change.

Top module: `mode_shifter`

## Requirements
- R1: While rst_n is low, q is all zeros and ovf is 0.
- R2: Operation code 000 (hold) leaves q unchanged on the next clock.
- R3: Operation code 001 (logical left) moves every bit up one position and loads sin_lo into bit 0.
- R4: Operation code 010 (logical right) moves every bit down one position and loads sin_hi into bit W-1.
- R5: Operation code 011 (rotate left) moves every bit up one position and loads the old bit W-1 into bit 0.
- R6: Operation code 100 (rotate right) moves every bit down one position and loads the old bit 0 into bit W-1.
- R7: Operation code 101 (arithmetic left) moves every bit up one position and loads 0 into bit 0. Both serial inputs are ignored.
- R8: Operation code 110 (arithmetic right) moves every bit down one position and keeps bit W-1 at its old value. Both serial inputs are ignored.
- R9: After an operation code 101, ovf equals the XOR of the two most significant bits of q as they were before the shift. After any other operation code, ovf is 0.
- R10: Operation code 111 (load) copies din into q on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation code |
| din | input | W | Parallel load word |
| sin_lo | input | 1 | Serial bit entering bit 0 on a logical left shift |
| sin_hi | input | 1 | Serial bit entering bit W-1 on a logical right shift |
| q | output | W | Register contents |
| ovf | output | 1 | Arithmetic left shift overflow flag |

## Verification
The bench aims at the sign-bit corners of the arithmetic modes. The values 0x40, 0x80 and 0xC0 separate a correct overflow flag from one that tests only the top bit or that uses the bits after the shift. A negative value under arithmetic right shift would expose a design that fills the top bit with zero. Arithmetic shifts are also run with both serial inputs set to 1, which catches a design that shares the logical fill path and lets the serial bit leak in. A hold issued straight after an overflow checks that the flag clears instead of being kept.

// File: rtl/mode_shifter.sv
module mode_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [W-1:0] din,
  input  logic         sin_lo,
  input  logic         sin_hi,
  output logic [W-1:0] q,
  output logic         ovf
);
  localparam logic [2:0] OP_HOLD = 3'd0;
  localparam logic [2:0] OP_SHL  = 3'd1;
  localparam logic [2:0] OP_SHR  = 3'd2;
  localparam logic [2:0] OP_CIL  = 3'd3;
  localparam logic [2:0] OP_CIR  = 3'd4;
  localparam logic [2:0] OP_ASHL = 3'd5;
  localparam logic [2:0] OP_ASHR = 3'd6;
  localparam logic [2:0] OP_LOAD = 3'd7;

  logic         fill_lo, fill_hi;
  logic [W-1:0] up, dn, nxt;

  always_comb begin
    fill_lo = 1'b0;
    fill_hi = 1'b0;
    case (op)
      OP_SHL:  fill_lo = sin_lo;
      OP_CIL:  fill_lo = q[W-1];
      OP_SHR:  fill_hi = sin_hi;
      OP_CIR:  fill_hi = q[0];
      OP_ASHR: fill_hi = q[W-1];
      default: ;
    endcase
  end

  assign up = {q[W-2:0], fill_lo};
  assign dn = {fill_hi, q[W-1:1]};

  always_comb begin
    case (op)
      OP_HOLD:                  nxt = q;
      OP_SHL, OP_CIL, OP_ASHL:  nxt = up;
      OP_SHR, OP_CIR, OP_ASHR:  nxt = dn;
      OP_LOAD:                  nxt = din;
      default:                  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      ovf <= 1'b0;
    end else begin
      q   <= nxt;
      ovf <= (op == OP_ASHL) ? (q[W-1] ^ q[W-2]) : 1'b0;
    end
  end
endmodule

// File: rtl/mode_shifter_chk.sv
module mode_shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op,
  input logic [W-1:0] din,
  input logic         sin_lo,
  input logic         sin_hi,
  input logic [W-1:0] q,
  input logic         ovf
);
  always_comb if (!rst_n) a_r1_reset: assert (q == '0 && !ovf);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd0 |=> q == $past(q));
  a_r3_shl: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd1 |=> q == {$past(q[W-2:0]), $past(sin_lo)});
  a_r4_shr: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd2 |=> q == {$past(sin_hi), $past(q[W-1:1])});
  a_r5_cil: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd3 |=> q == {$past(q[W-2:0]), $past(q[W-1])});
  a_r6_cir: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd4 |=> q == {$past(q[0]), $past(q[W-1:1])});
  a_r7_ashl: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd5 |=> q == {$past(q[W-2:0]), 1'b0});
  a_r8_ashr: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd6 |=> q == {$past(q[W-1]), $past(q[W-1:1])});
  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd5 |=> ovf == ($past(q[W-1]) ^ $past(q[W-2])));
  a_r9_ovf_clr: assert property (@(posedge clk) disable iff (!rst_n)
    op != 3'd5 |=> !ovf);
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'd7 |=> q == $past(din));
endmodule

bind mode_shifter mode_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .din(din), .sin_lo(sin_lo),
  .sin_hi(sin_hi), .q(q), .ovf(ovf)
);

// File: tb/tb_mode_shifter.sv
module tb_mode_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op = 3'd0;
  logic [W-1:0] din = '0;
  logic         sin_lo = 1'b0;
  logic         sin_hi = 1'b0;
  logic [W-1:0] q;
  logic         ovf;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] mq = '0;
  logic         movf = 1'b0;

  always #2 clk = ~clk;

  mode_shifter #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op(op), .din(din),
    .sin_lo(sin_lo), .sin_hi(sin_hi), .q(q), .ovf(ovf)
  );

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [W-1:0] model_q(input logic [2:0] o, input logic [W-1:0] r,
                                           input logic [W-1:0] d, input logic sl, input logic sh);
    case (o)
      3'd1: return (r << 1) | W'(sl);
      3'd2: return (r >> 1) | ({W{sh}} & (W'(1) << (W-1)));
      3'd3: return (r << 1) | W'(r[W-1]);
      3'd4: return (r >> 1) | ({W{r[0]}} & (W'(1) << (W-1)));
      3'd5: return r << 1;
      3'd6: return (r >> 1) | (r & (W'(1) << (W-1)));
      3'd7: return d;
      default: return r;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [W-1:0] d, input logic sl, input logic sh);
    logic [W-1:0] eq;
    logic         ev;
    @(negedge clk);
    op = o; din = d; sin_lo = sl; sin_hi = sh;
    eq = model_q(o, mq, d, sl, sh);
    ev = (o == 3'd5) ? (mq[W-1] ^ mq[W-2]) : 1'b0;
    @(posedge clk);
    #1;
    check(req_of(o), q, eq);
    check("R9", W'(ovf), W'(ev));
    mq = eq;
    movf = ev;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", q, '0);
    check("R1", W'(ovf), '0);
    rst_n = 1'b1;
    step(3'd7, 8'h40, 1'b1, 1'b1);
    step(3'd5, 8'h00, 1'b1, 1'b1);
    step(3'd0, 8'h00, 1'b1, 1'b1);
    step(3'd7, 8'hC0, 1'b0, 1'b0);
    step(3'd5, 8'h00, 1'b1, 1'b1);
    step(3'd7, 8'h80, 1'b0, 1'b0);
    step(3'd5, 8'h00, 1'b1, 1'b1);
    step(3'd7, 8'h81, 1'b0, 1'b0);
    step(3'd6, 8'h00, 1'b0, 1'b0);
    step(3'd6, 8'h00, 1'b1, 1'b1);
    step(3'd7, 8'h01, 1'b0, 1'b0);
    step(3'd4, 8'h00, 1'b0, 1'b0);
    step(3'd3, 8'h00, 1'b0, 1'b0);
    step(3'd2, 8'h00, 1'b0, 1'b1);
    step(3'd1, 8'h00, 1'b1, 1'b0);
    for (int i = 0; i < 400; i++)
      step(3'($urandom), W'($urandom), 1'($urandom), 1'($urandom));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule